// File: doc/BRIEF.md
# Programmable Multiplexer Channel Sequencer

This block chooses which of eight analog inputs a converter samples next. The host fills a 16-entry table through a byte-wide register write port. Each entry pairs a 3-bit input number with an 8-bit repeat count. The host also sets a first and a last table index, a wrap enable, a 2-bit mode field and a command byte.

Once launched, the sequencer moves forward by one conversion each time chip select rises. The chip select input is synchronized inside the block. Each entry is held for its repeat count, and the run covers the entries from the first index to the last index. With wrap enabled, the run starts again at the first index after the last one. Without wrap, the run ends: the channel select returns to input 0 and the busy status stops being driven.

The outputs are the selected input, the table index being executed, and a busy level together with its output enable. The output enable feeds a tri-state status pin.

Top module: `chan_seq`

## Requirements
- R1: After reset, `chan_sel` = 0, `seq_busy` = 0, `busy_oe` = 0 and `idx_tag` = 0. The first index resets to 0, the last index to 15, the mode to 0 and the wrap enable to 0.
- R2: A write to address 0x8C+2k (k = 0..15) stores data[2:0] as the input number of entry k. A write to 0x8D+2k stores data[7:0] as the repeat count of entry k. After reset, every entry holds input 0 with count 1.
- R3: A write to the command register (0x02) with bit0 = 1 and bit1 = 0, made while idle and while the mode register (0x01, bits[1:0]) holds 11b, starts a run on the next clock. The run begins with `chan_sel` = the input of the first-index entry, `idx_tag` = first index, and `seq_busy` = `busy_oe` = 1. In any other mode the start write does nothing.
- R4: Each synchronized rising edge of `cs_n` counts one conversion. An entry with count N stays selected for N edges, and a count of 0 behaves as 1. `chan_sel`, `idx_tag` and `busy_oe` change only on such an edge or on a register write.
- R5: The entries run in ascending index order from the first index (0x03, bits[3:0]) to the last index (0x04, bits[3:0]).
- R6: With wrap disabled (0x05 bit0 = 0), the edge that completes the last conversion of the last entry drops `seq_busy` and `busy_oe` to 0 and sets `chan_sel` and `idx_tag` to 0. Later edges leave them at 0.
- R7: With wrap enabled, the edge that completes the last entry moves execution back to the first-index entry, and `busy_oe` stays at 1.
- R8: If the first index is greater than the last index, only the first-index entry runs before the run ends or wraps.
- R9: A command write with bit1 = 1 (abort), or a start write made during a run, returns the block to idle with input 0 selected. A command write takes priority over a chip-select edge detected in the same cycle.
- R10: Table and index writes made during a run are used at the next entry fetch. The entry that is currently selected does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Converter chip select, asynchronous; its rising edge ends a conversion frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| chan_sel | output | 3 | Selected multiplexer input |
| seq_busy | output | 1 | Busy level for the status pin |
| busy_oe | output | 1 | Output enable of the status pin driver |
| idx_tag | output | 4 | Table index being executed |

## Verification
A detected chip-select edge and a command write can land in the same clock cycle. The bench provokes this by raising `cs_n` and then placing an abort write, or a start write while idle, in the exact cycle in which the synchronized edge is acted on. A correct design lets the command win. After the abort, the outputs show idle with input 0 and no step. After the start, the run begins at the first-index entry and has not advanced.

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int N_ENT   = 16,
  parameter int CH_W    = 3,
  parameter int CNT_W   = 8,
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter logic [7:0] TBL_BASE = 8'h8C,
  parameter logic [7:0] A_MODE   = 8'h01,
  parameter logic [7:0] A_CMD    = 8'h02,
  parameter logic [7:0] A_FIRST  = 8'h03,
  parameter logic [7:0] A_LAST   = 8'h04,
  parameter logic [7:0] A_WRAP   = 8'h05
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [CH_W-1:0] chan_sel,
  output logic            seq_busy,
  output logic            busy_oe,
  output logic [$clog2(N_ENT)-1:0] idx_tag
);
  localparam int IW = $clog2(N_ENT);

  logic [CH_W-1:0]  ch_tbl  [N_ENT];
  logic [CNT_W-1:0] cnt_tbl [N_ENT];
  logic [IW-1:0]    first_ix, last_ix, idx;
  logic [1:0]       mode;
  logic             wrap_en, running;
  logic [CNT_W-1:0] rep_left;
  logic [2:0]       cs_sync;
  logic             cs_rise;

  logic [AW-1:0] toff;
  logic          tbl_hit, cmd_wr, is_last;
  logic [IW-1:0] next_ix, fetch_ix;

  assign toff    = wr_addr - AW'(TBL_BASE);
  assign tbl_hit = wr_en && (wr_addr >= AW'(TBL_BASE)) && (toff < AW'(2 * N_ENT));
  assign cmd_wr  = wr_en && (wr_addr == AW'(A_CMD));
  assign cs_rise = cs_sync[1] & ~cs_sync[2];
  // an inverted range also ends here, since idx then starts above last_ix
  assign is_last = (idx >= last_ix);
  assign next_ix = idx + IW'(1);
  assign fetch_ix = is_last ? first_ix : next_ix;

  function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_sync <= '1;
    else        cs_sync <= {cs_sync[1:0], cs_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        ch_tbl[i]  <= '0;
        cnt_tbl[i] <= CNT_W'(1);
      end
      first_ix <= '0;
      last_ix  <= IW'(N_ENT - 1);
      mode     <= '0;
      wrap_en  <= 1'b0;
    end else if (wr_en) begin
      if (tbl_hit) begin
        if (toff[0]) cnt_tbl[toff[IW:1]] <= wr_data[CNT_W-1:0];
        else         ch_tbl[toff[IW:1]]  <= wr_data[CH_W-1:0];
      end
      if (wr_addr == AW'(A_MODE))  mode     <= wr_data[1:0];
      if (wr_addr == AW'(A_FIRST)) first_ix <= wr_data[IW-1:0];
      if (wr_addr == AW'(A_LAST))  last_ix  <= wr_data[IW-1:0];
      if (wr_addr == AW'(A_WRAP))  wrap_en  <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      idx      <= '0;
      rep_left <= '0;
      chan_sel <= '0;
    end else if (cmd_wr && (wr_data[1] || (wr_data[0] && running))) begin
      running  <= 1'b0;
      idx      <= '0;
      rep_left <= '0;
      chan_sel <= '0;
    end else if (cmd_wr && wr_data[0] && mode == 2'b11) begin
      running  <= 1'b1;
      idx      <= first_ix;
      rep_left <= eff_cnt(cnt_tbl[first_ix]);
      chan_sel <= ch_tbl[first_ix];
    end else if (running && cs_rise && !cmd_wr) begin
      if (rep_left > CNT_W'(1)) begin
        rep_left <= rep_left - CNT_W'(1);
      end else if (is_last && !wrap_en) begin
        running  <= 1'b0;
        idx      <= '0;
        rep_left <= '0;
        chan_sel <= '0;
      end else begin
        idx      <= fetch_ix;
        rep_left <= eff_cnt(cnt_tbl[fetch_ix]);
        chan_sel <= ch_tbl[fetch_ix];
      end
    end
  end

  assign seq_busy = running;
  assign busy_oe  = running;
  assign idx_tag  = idx;
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk #(
  parameter int CH_W = 3,
  parameter int IW   = 4,
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter logic [7:0] A_CMD = 8'h02
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [CH_W-1:0] chan_sel,
  input logic            busy_oe,
  input logic [IW-1:0]   idx_tag,
  input logic            cs_rise,
  input logic [1:0]      mode
);
  logic cmd;
  assign cmd = wr_en && (wr_addr == AW'(A_CMD));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !wr_en) |=> ($stable(chan_sel) && $stable(idx_tag) && $stable(busy_oe)));

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_oe |-> (chan_sel == '0 && idx_tag == '0));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wr_data[1]) |=> !busy_oe);

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_oe && cmd && wr_data[1:0] == 2'b01 && mode == 2'b11) |=> busy_oe);

  p_nolaunch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_oe && cmd && mode != 2'b11) |=> !busy_oe);
endmodule

bind chan_seq chan_seq_chk #(.CH_W(CH_W), .IW(IW), .AW(AW), .DW(DW), .A_CMD(A_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .chan_sel(chan_sel), .busy_oe(busy_oe), .idx_tag(idx_tag), .cs_rise(cs_rise), .mode(mode)
);

// File: tb/tb_chan_seq.sv
module tb_chan_seq;
  logic clk = 0, rst_n = 0, cs_n = 1, wr_en = 0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [2:0] chan_sel;
  logic seq_busy, busy_oe;
  logic [3:0] idx_tag;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  chan_seq dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_sel(chan_sel), .seq_busy(seq_busy), .busy_oe(busy_oe), .idx_tag(idx_tag));

  // vector: [31:30] op (0 write, 1 frame), [29:22] addr, [21:14] data,
  // [13:11] ch, [10] busy, [9:6] idx, [3:0] requirement number
  function automatic logic [31:0] mk(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                                     input logic [2:0] ch, input logic b, input logic [3:0] ix,
                                     input logic [3:0] r);
    return {op, a, d, ch, b, ix, 2'b00, r};
  endfunction

  localparam int NV = 39;
  localparam logic [31:0] VEC [NV] = '{
    mk(0,8'h8C,2,0,0,0,2), mk(0,8'h8D,1,0,0,0,2), mk(0,8'h8E,6,0,0,0,2), mk(0,8'h8F,1,0,0,0,2),
    mk(0,8'h90,5,0,0,0,2), mk(0,8'h91,3,0,0,0,2), mk(0,8'h92,7,0,0,0,2), mk(0,8'h93,0,0,0,0,2),
    mk(0,8'h04,3,0,0,0,5),
    mk(0,8'h02,1,0,0,0,3),                     // R3 start ignored in mode 0
    mk(0,8'h01,3,0,0,0,3), mk(0,8'h02,1,2,1,0,3),
    mk(1,0,0,6,1,1,5),                          // R5
    mk(1,0,0,5,1,2,4), mk(1,0,0,5,1,2,4), mk(1,0,0,5,1,2,4), // R4 count 3
    mk(1,0,0,7,1,3,4),                          // R4 count 0 acts as 1
    mk(1,0,0,0,0,0,6), mk(1,0,0,0,0,0,6),       // R6
    mk(0,8'h05,1,0,0,0,7), mk(0,8'h03,1,0,0,0,7), mk(0,8'h04,2,0,0,0,7),
    mk(0,8'h02,1,6,1,1,3),
    mk(1,0,0,5,1,2,5), mk(1,0,0,5,1,2,4), mk(1,0,0,5,1,2,4),
    mk(1,0,0,6,1,1,7),                          // R7 wrap
    mk(0,8'h02,2,0,0,0,9),                      // R9 abort
    mk(0,8'h05,0,0,0,0,8), mk(0,8'h03,3,0,0,0,8), mk(0,8'h04,1,0,0,0,8),
    mk(0,8'h02,1,7,1,3,8), mk(1,0,0,0,0,0,8),   // R8 inverted range
    mk(0,8'h03,0,0,0,0,10), mk(0,8'h04,3,0,0,0,10),
    mk(0,8'h02,1,2,1,0,10), mk(0,8'h8E,4,2,1,0,10), mk(1,0,0,4,1,1,10), // R10
    mk(0,8'h02,1,0,0,0,9)                       // R9 restart while running
  };

  task automatic check(input logic [2:0] ch, input logic b, input logic [3:0] ix, input int r);
    n_chk++;
    if (chan_sel !== ch || seq_busy !== b || busy_oe !== b || idx_tag !== ix) begin
      n_bad++;
      $display("FAIL R%0d: ch=%0d busy=%0b oe=%0b idx=%0d, expected ch=%0d busy=%0b oe=%0b idx=%0d",
               r, chan_sel, seq_busy, busy_oe, idx_tag, ch, b, b, ix);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic frame();
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // cs_n rise and a command write acted on at the same clock edge
  task automatic frame_with_cmd(input logic [7:0] d);
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (2) @(negedge clk);
    wr_en = 1; wr_addr = 8'h02; wr_data = d;
    @(negedge clk); wr_en = 0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, 0, 0, 1);                          // R1 in reset
    rst_n = 1;
    @(negedge clk);
    check(0, 0, 0, 1);                          // R1 after release

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:30] == 2'd0) wr(VEC[i][29:22], VEC[i][21:14]);
      else frame();
      check(VEC[i][13:11], VEC[i][10], VEC[i][9:6], int'(VEC[i][3:0]));
    end

    // R9 abort coincides with a detected edge
    wr(8'h02, 1); check(2, 1, 0, 9);
    frame();      check(4, 1, 1, 9);
    frame_with_cmd(8'h02); check(0, 0, 0, 9);
    frame();      check(0, 0, 0, 6);
    // R9 start coincides with an edge: run begins at first entry, not advanced
    frame_with_cmd(8'h01); check(2, 1, 0, 9);

    // R1 reset during a run, then R2 default table contents
    @(negedge clk); rst_n = 0;
    @(negedge clk); check(0, 0, 0, 1);
    rst_n = 1;
    wr(8'h01, 3);
    wr(8'h02, 1); check(0, 1, 0, 2);
    frame();      check(0, 1, 1, 2);            // R2 default count 1
    wr(8'h03, 15);
    wr(8'h02, 2); check(0, 0, 0, 9);
    wr(8'h02, 1); check(0, 1, 15, 2);           // R1 last index reset 15
    frame();      check(0, 0, 0, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule